// File: doc/BRIEF.md
# Decimating Subset Extraction Engine

The engine prepares a readout image in a byte-wide SRAM from a capture window that is already filled. Each accepted start builds the image in order. First it writes two decimated subsets of the capture window, each with its own stride. The second subset begins at an offset derived from the first stride and a shift factor. Next come a fixed three-byte end marker and a short tail, which is copied from inside the image it has just written. The readout pointer goes back to the first image byte.

The engine makes one SRAM access per clock. The SRAM returns read data one cycle after the read command. Each stored byte therefore takes a read cycle and a write cycle. The caller asserts `start_i` with the strides and shift on the same cycle and waits for the one-cycle `done_o`. A separate advance input steps the readout pointer for the consumer of the image. The pointer wraps back to the image base after a top address.

Top module: `subset_extract`

## Requirements
- R1: While reset is held and after it: `busy_o` and `done_o` are low, there is no SRAM access, and `rd_ptr_o` equals `DST_BASE`.
- R2: Image byte k (k < `SUB_LEN`), at address `DST_BASE`+k, holds the source byte at index (k·step1) mod `SRC_LEN`. Source index i lives at address `SRC_BASE`+i.
- R3: Image byte `SUB_LEN`+k holds the source byte at index (F + k·step2) mod `SRC_LEN`, where F = (5·step1·shift) mod `SRC_LEN`.
- R4: Image bytes 2·`SUB_LEN`, 2·`SUB_LEN`+1 and 2·`SUB_LEN`+2 hold 0x01, 0xFE and 0x80, in that order.
- R5: Image byte 2·`SUB_LEN`+3+k (k < `TAIL_LEN`) equals image byte `TAIL_OFS`+k of the same run.
- R6: There is never both a read and a write in one cycle. Every write falls inside the image. Every read falls inside the image or the source window. All SRAM bytes outside the image keep their values.
- R7: `done_o` is high for exactly one cycle. Counting the clock edge that accepts the start as edge 1, `done_o` is first seen after edge 5·shift + 4·`SUB_LEN` + 2·`TAIL_LEN` + 4. `busy_o` is high from the accepting edge until `done_o` falls.
- R8: A start that arrives while busy is ignored. Stride or shift inputs that change during a run have no effect on its image or its length.
- R9: An accepted start sets `rd_ptr_o` to `DST_BASE` at the accepting edge.
- R10: Each `rd_adv_i` cycle with no accepted start increments `rd_ptr_o`. From `RD_TOP` it wraps to `DST_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request; accepted only when idle |
| step1_i | input | STEP_W | Stride of the first subset, less than SRC_LEN |
| step2_i | input | STEP_W | Stride of the second subset, less than SRC_LEN |
| shift_i | input | STEP_W | Offset factor for the second subset start |
| rd_adv_i | input | 1 | Advance the readout pointer by one |
| busy_o | output | 1 | Preparation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_ptr_o | output | ADDR_W | Readout pointer |
| mem_addr_o | output | ADDR_W | SRAM address |
| mem_re_o | output | 1 | SRAM read command |
| mem_we_o | output | 1 | SRAM write command |
| mem_wdata_o | output | 8 | SRAM write data |
| mem_rdata_i | input | 8 | SRAM read data, valid one cycle after the read |

## Verification
The bench shrinks the parameters so that the whole address space fits in a 256-byte model: an 8-bit address, a 100-byte source window at 0x90, six-byte subsets at 0x10, and a four-byte tail copied from image offset 8. With these sizes, strides up to 99 and a shift of 255 make both subsets and the start offset wrap several times around the source window. A full pointer wrap from `RD_TOP` takes fewer than 250 advances. The small image also lets the bench compare every byte and the rest of memory on every run.

// File: rtl/subset_extract_pkg.sv
package subset_extract_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFFS,
        ST_A_RD,
        ST_A_WR,
        ST_B_RD,
        ST_B_WR,
        ST_SIG,
        ST_T_RD,
        ST_T_WR,
        ST_FIN
    } sxe_state_e;

    // accumulator command: load has priority over add
    typedef struct packed {
        logic load;
        logic add;
    } acc_cmd_t;

    localparam int SIG_LEN  = 3;
    localparam int OFS_MULT = 5;

    function automatic logic [7:0] sig_byte(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h01;
            2'd1:    return 8'hFE;
            default: return 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/sxe_wrap_acc.sv
module sxe_wrap_acc #(
    parameter int IDX_W  = 13,
    parameter int STEP_W = 8,
    parameter int LEN    = 5000
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  subset_extract_pkg::acc_cmd_t         cmd_i,
    input  logic [IDX_W-1:0]                     load_val_i,
    input  logic [STEP_W-1:0]                    step_i,
    output logic [IDX_W-1:0]                     val_o
);
    localparam int SUM_W = ((IDX_W > STEP_W) ? IDX_W : STEP_W) + 1;

    logic [IDX_W-1:0] val_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    // single conditional subtraction: the step must stay below LEN
    always_comb begin
        sum = SUM_W'(val_q) + SUM_W'(step_i);
        if (sum >= SUM_W'(LEN)) begin
            wrapped = sum - SUM_W'(LEN);
        end else begin
            wrapped = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (cmd_i.load) begin
            val_q <= load_val_i;
        end else if (cmd_i.add) begin
            val_q <= IDX_W'(wrapped);
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/sxe_rdptr.sv
module sxe_rdptr #(
    parameter int ADDR_W = 16,
    parameter int BASE   = 16'h4000,
    parameter int TOP    = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            ptr_q <= ADDR_W'(BASE);
        end else if (adv_i) begin
            if (ptr_q == ADDR_W'(TOP)) begin
                ptr_q <= ADDR_W'(BASE);
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/sxe_seq.sv
module sxe_seq
    import subset_extract_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int STEP_W   = 8,
    parameter int IDX_W    = 13,
    parameter int SRC_BASE = 16'h6000,
    parameter int DST_BASE = 16'h4000,
    parameter int SUB_LEN  = 500,
    parameter int TAIL_OFS = 800,
    parameter int TAIL_LEN = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [STEP_W-1:0] step1_i,
    input  logic [STEP_W-1:0] step2_i,
    input  logic [STEP_W-1:0] shift_i,
    input  logic [IDX_W-1:0]  src_idx_i,
    input  logic [IDX_W-1:0]  ofs_idx_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              accept_o,
    output acc_cmd_t          ofs_cmd_o,
    output logic [STEP_W-1:0] ofs_step_o,
    output acc_cmd_t          idx_cmd_o,
    output logic [IDX_W-1:0]  idx_load_val_o,
    output logic [STEP_W-1:0] idx_step_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o
);
    localparam int IMG_LEN = 2 * SUB_LEN + SIG_LEN + TAIL_LEN;
    localparam int CNT_W   = $clog2(IMG_LEN + 1);
    localparam int REP_W   = STEP_W + 3;
    localparam logic [CNT_W-1:0] SUB_LAST  = CNT_W'(SUB_LEN - 1);
    localparam logic [CNT_W-1:0] SIG_LAST  = CNT_W'(SIG_LEN - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'((TAIL_LEN > 0) ? TAIL_LEN - 1 : 0);

    sxe_state_e        state_q;
    logic [STEP_W-1:0] s1_q;
    logic [STEP_W-1:0] s2_q;
    logic [REP_W-1:0]  rep_q;
    logic [CNT_W-1:0]  pcnt_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic              sub_end;

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign sub_end  = (pcnt_q == SUB_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            s1_q    <= '0;
            s2_q    <= '0;
            rep_q   <= '0;
            pcnt_q  <= '0;
            wcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        s1_q    <= step1_i;
                        s2_q    <= step2_i;
                        rep_q   <= REP_W'(shift_i) * REP_W'(OFS_MULT);
                        pcnt_q  <= '0;
                        wcnt_q  <= '0;
                        state_q <= (shift_i == '0) ? ST_A_RD : ST_OFFS;
                    end
                end
                ST_OFFS: begin
                    rep_q <= rep_q - 1'b1;
                    if (rep_q == REP_W'(1)) begin
                        state_q <= ST_A_RD;
                    end
                end
                ST_A_RD: state_q <= ST_A_WR;
                ST_A_WR: begin
                    wcnt_q <= wcnt_q + 1'b1;
                    if (sub_end) begin
                        pcnt_q  <= '0;
                        state_q <= ST_B_RD;
                    end else begin
                        pcnt_q  <= pcnt_q + 1'b1;
                        state_q <= ST_A_RD;
                    end
                end
                ST_B_RD: state_q <= ST_B_WR;
                ST_B_WR: begin
                    wcnt_q <= wcnt_q + 1'b1;
                    if (sub_end) begin
                        pcnt_q  <= '0;
                        state_q <= ST_SIG;
                    end else begin
                        pcnt_q  <= pcnt_q + 1'b1;
                        state_q <= ST_B_RD;
                    end
                end
                ST_SIG: begin
                    wcnt_q <= wcnt_q + 1'b1;
                    if (pcnt_q == SIG_LAST) begin
                        pcnt_q  <= '0;
                        state_q <= (TAIL_LEN > 0) ? ST_T_RD : ST_FIN;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                ST_T_RD: state_q <= ST_T_WR;
                ST_T_WR: begin
                    wcnt_q <= wcnt_q + 1'b1;
                    if (pcnt_q == TAIL_LAST) begin
                        state_q <= ST_FIN;
                    end else begin
                        pcnt_q  <= pcnt_q + 1'b1;
                        state_q <= ST_T_RD;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // accumulator control
    always_comb begin
        ofs_cmd_o.load = accept_o;
        ofs_cmd_o.add  = (state_q == ST_OFFS);
        ofs_step_o     = s1_q;

        idx_cmd_o.load = accept_o || ((state_q == ST_A_WR) && sub_end);
        idx_cmd_o.add  = ((state_q == ST_A_WR) && !sub_end) || (state_q == ST_B_WR);
        idx_load_val_o = accept_o ? '0 : ofs_idx_i;
        idx_step_o     = (state_q == ST_A_WR) ? s1_q : s2_q;
    end

    // SRAM command
    always_comb begin
        mem_addr_o  = '0;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        case (state_q)
            ST_A_RD, ST_B_RD: begin
                mem_re_o   = 1'b1;
                mem_addr_o = ADDR_W'(SRC_BASE) + ADDR_W'(src_idx_i);
            end
            ST_A_WR, ST_B_WR, ST_T_WR: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ADDR_W'(DST_BASE) + ADDR_W'(wcnt_q);
                mem_wdata_o = mem_rdata_i;
            end
            ST_SIG: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ADDR_W'(DST_BASE) + ADDR_W'(wcnt_q);
                mem_wdata_o = sig_byte(pcnt_q[1:0]);
            end
            ST_T_RD: begin
                mem_re_o   = 1'b1;
                mem_addr_o = ADDR_W'(DST_BASE) + ADDR_W'(TAIL_OFS) + ADDR_W'(pcnt_q);
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_FIN);

endmodule

// File: rtl/subset_extract.sv
module subset_extract
    import subset_extract_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int STEP_W   = 8,
    parameter int SRC_BASE = 16'h6000,
    parameter int SRC_LEN  = 5000,
    parameter int DST_BASE = 16'h4000,
    parameter int SUB_LEN  = 500,
    parameter int TAIL_OFS = 800,
    parameter int TAIL_LEN = 100,
    parameter int RD_TOP   = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [STEP_W-1:0] step1_i,
    input  logic [STEP_W-1:0] step2_i,
    input  logic [STEP_W-1:0] shift_i,
    input  logic              rd_adv_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] rd_ptr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int IDX_W = $clog2(SRC_LEN);

    logic              accept;
    acc_cmd_t          ofs_cmd;
    acc_cmd_t          idx_cmd;
    logic [STEP_W-1:0] ofs_step;
    logic [STEP_W-1:0] idx_step;
    logic [IDX_W-1:0]  idx_load_val;
    logic [IDX_W-1:0]  ofs_idx;
    logic [IDX_W-1:0]  src_idx;

    sxe_seq #(
        .ADDR_W  (ADDR_W),
        .STEP_W  (STEP_W),
        .IDX_W   (IDX_W),
        .SRC_BASE(SRC_BASE),
        .DST_BASE(DST_BASE),
        .SUB_LEN (SUB_LEN),
        .TAIL_OFS(TAIL_OFS),
        .TAIL_LEN(TAIL_LEN)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .step1_i       (step1_i),
        .step2_i       (step2_i),
        .shift_i       (shift_i),
        .src_idx_i     (src_idx),
        .ofs_idx_i     (ofs_idx),
        .mem_rdata_i   (mem_rdata_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .accept_o      (accept),
        .ofs_cmd_o     (ofs_cmd),
        .ofs_step_o    (ofs_step),
        .idx_cmd_o     (idx_cmd),
        .idx_load_val_o(idx_load_val),
        .idx_step_o    (idx_step),
        .mem_addr_o    (mem_addr_o),
        .mem_re_o      (mem_re_o),
        .mem_we_o      (mem_we_o),
        .mem_wdata_o   (mem_wdata_o)
    );

    // second-subset start offset
    sxe_wrap_acc #(.IDX_W(IDX_W), .STEP_W(STEP_W), .LEN(SRC_LEN)) u_ofs_acc (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (ofs_cmd),
        .load_val_i('0),
        .step_i    (ofs_step),
        .val_o     (ofs_idx)
    );

    // running source index
    sxe_wrap_acc #(.IDX_W(IDX_W), .STEP_W(STEP_W), .LEN(SRC_LEN)) u_idx_acc (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (idx_cmd),
        .load_val_i(idx_load_val),
        .step_i    (idx_step),
        .val_o     (src_idx)
    );

    sxe_rdptr #(.ADDR_W(ADDR_W), .BASE(DST_BASE), .TOP(RD_TOP)) u_rdptr (
        .clk   (clk),
        .rst   (rst),
        .load_i(accept),
        .adv_i (rd_adv_i),
        .ptr_o (rd_ptr_o)
    );

endmodule

// File: rtl/subset_extract_chk.sv
module subset_extract_chk #(
    parameter int ADDR_W   = 16,
    parameter int SRC_BASE = 16'h6000,
    parameter int SRC_LEN  = 5000,
    parameter int DST_BASE = 16'h4000,
    parameter int SUB_LEN  = 500,
    parameter int TAIL_LEN = 100,
    parameter int RD_TOP   = 16'h7FFF
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              rd_adv_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] rd_ptr_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_re_o,
    input logic              mem_we_o
);
    localparam int IMG_LEN = 2 * SUB_LEN + 3 + TAIL_LEN;
    localparam logic [ADDR_W-1:0] IMG_LO = ADDR_W'(DST_BASE);
    localparam logic [ADDR_W-1:0] IMG_HI = ADDR_W'(DST_BASE + IMG_LEN - 1);
    localparam logic [ADDR_W-1:0] SRC_LO = ADDR_W'(SRC_BASE);
    localparam logic [ADDR_W-1:0] SRC_HI = ADDR_W'(SRC_BASE + SRC_LEN - 1);
    localparam logic [ADDR_W-1:0] PTR_LO = ADDR_W'(DST_BASE);
    localparam logic [ADDR_W-1:0] PTR_HI = ADDR_W'(RD_TOP);

    logic accepted;
    assign accepted = start_i && !busy_o;

    assert_one_access_R6: assert property (@(posedge clk) disable iff (rst)
        !(mem_re_o && mem_we_o));

    assert_write_window_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (mem_addr_o >= IMG_LO && mem_addr_o <= IMG_HI));

    assert_read_window_R6: assert property (@(posedge clk) disable iff (rst)
        mem_re_o |-> ((mem_addr_o >= IMG_LO && mem_addr_o <= IMG_HI) ||
                      (mem_addr_o >= SRC_LO && mem_addr_o <= SRC_HI)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mem_re_o && !mem_we_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    assert_busy_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_start_ptr_R9: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (rd_ptr_o == PTR_LO));

    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr_o >= PTR_LO) && (rd_ptr_o <= PTR_HI));

    assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_adv_i && !accepted && rd_ptr_o == PTR_HI) |=> (rd_ptr_o == PTR_LO));

endmodule

bind subset_extract subset_extract_chk #(
    .ADDR_W  (ADDR_W),
    .SRC_BASE(SRC_BASE),
    .SRC_LEN (SRC_LEN),
    .DST_BASE(DST_BASE),
    .SUB_LEN (SUB_LEN),
    .TAIL_LEN(TAIL_LEN),
    .RD_TOP  (RD_TOP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .rd_adv_i  (rd_adv_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_ptr_o  (rd_ptr_o),
    .mem_addr_o(mem_addr_o),
    .mem_re_o  (mem_re_o),
    .mem_we_o  (mem_we_o)
);

// File: tb/subset_extract_tb.sv
module subset_extract_tb;

    localparam int ADDR_W   = 8;
    localparam int STEP_W   = 8;
    localparam int SRC_BASE = 8'h90;
    localparam int SRC_LEN  = 100;
    localparam int DST_BASE = 8'h10;
    localparam int SUB_LEN  = 6;
    localparam int TAIL_OFS = 8;
    localparam int TAIL_LEN = 4;
    localparam int RD_TOP   = 8'hFF;
    localparam int IMG_LEN  = 2 * SUB_LEN + 3 + TAIL_LEN;
    localparam int MEM_SZ   = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [STEP_W-1:0] step1 = '0;
    logic [STEP_W-1:0] step2 = '0;
    logic [STEP_W-1:0] shift = '0;
    logic              rd_adv = 1'b0;
    logic              busy;
    logic              done;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_re;
    logic              mem_we;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;

    logic [7:0] mem  [MEM_SZ];
    logic [7:0] snap [MEM_SZ];

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    subset_extract #(
        .ADDR_W(ADDR_W), .STEP_W(STEP_W), .SRC_BASE(SRC_BASE), .SRC_LEN(SRC_LEN),
        .DST_BASE(DST_BASE), .SUB_LEN(SUB_LEN), .TAIL_OFS(TAIL_OFS),
        .TAIL_LEN(TAIL_LEN), .RD_TOP(RD_TOP)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .step1_i(step1), .step2_i(step2),
        .shift_i(shift), .rd_adv_i(rd_adv), .busy_o(busy), .done_o(done),
        .rd_ptr_o(rd_ptr), .mem_addr_o(mem_addr), .mem_re_o(mem_re),
        .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // SRAM model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(!mem_re && !mem_we, "R1 no access", {mem_re, mem_we}, 0);
        chk(rd_ptr == ADDR_W'(DST_BASE), "R1 rd_ptr", rd_ptr, DST_BASE);
    endtask

    // one preparation run; poke injects a start with other values mid-run (R8)
    task automatic run_prep(input int s1, input int s2, input int x, input bit poke);
        int n;
        int exp_n;
        int ofs;
        int bad;
        int exp_img [IMG_LEN];
        for (int a = 0; a < MEM_SZ; a++) snap[a] = mem[a];
        @(negedge clk);
        step1 = STEP_W'(s1);
        step2 = STEP_W'(s2);
        shift = STEP_W'(x);
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_ptr == ADDR_W'(DST_BASE), "R9 pointer rebased", rd_ptr, DST_BASE);
        chk(busy == 1'b1, "R7 busy after accept", busy, 1);
        while (!done && n < 5000) begin
            if (poke && n == 4) begin
                start = 1'b1;
                step1 = 8'd3;
                step2 = 8'd5;
                shift = 8'd9;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        exp_n = 5 * x + 4 * SUB_LEN + 2 * TAIL_LEN + 4;
        chk(n == exp_n, poke ? "R8 run length unchanged" : "R7 run length", n, exp_n);
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R7 done single cycle", {done, busy}, 0);

        ofs = (5 * s1 * x) % SRC_LEN;
        for (int k = 0; k < SUB_LEN; k++) begin
            exp_img[k]           = snap[SRC_BASE + (k * s1) % SRC_LEN];
            exp_img[SUB_LEN + k] = snap[SRC_BASE + (ofs + k * s2) % SRC_LEN];
        end
        exp_img[2 * SUB_LEN]     = 8'h01;
        exp_img[2 * SUB_LEN + 1] = 8'hFE;
        exp_img[2 * SUB_LEN + 2] = 8'h80;
        for (int k = 0; k < TAIL_LEN; k++)
            exp_img[2 * SUB_LEN + 3 + k] = exp_img[TAIL_OFS + k];

        for (int k = 0; k < IMG_LEN; k++) begin
            if (k < SUB_LEN)
                chk(int'(mem[DST_BASE + k]) == exp_img[k],
                    poke ? "R8 first subset" : "R2 first subset", mem[DST_BASE + k], exp_img[k]);
            else if (k < 2 * SUB_LEN)
                chk(int'(mem[DST_BASE + k]) == exp_img[k],
                    poke ? "R8 second subset" : "R3 second subset", mem[DST_BASE + k], exp_img[k]);
            else if (k < 2 * SUB_LEN + 3)
                chk(int'(mem[DST_BASE + k]) == exp_img[k], "R4 signature",
                    mem[DST_BASE + k], exp_img[k]);
            else
                chk(int'(mem[DST_BASE + k]) == exp_img[k], "R5 tail copy",
                    mem[DST_BASE + k], exp_img[k]);
        end

        bad = 0;
        for (int a = 0; a < MEM_SZ; a++)
            if ((a < DST_BASE || a >= DST_BASE + IMG_LEN) && mem[a] !== snap[a]) bad++;
        chk(bad == 0, "R6 bytes outside image untouched", bad, 0);
    endtask

    task automatic t_pointer();
        int target;
        @(negedge clk);
        rd_adv = 1'b1;
        repeat (5) @(negedge clk);
        rd_adv = 1'b0;
        chk(rd_ptr == ADDR_W'(DST_BASE + 5), "R10 advance", rd_ptr, DST_BASE + 5);
        run_prep(2, 3, 1, 1'b0);  // R9 checked inside: pointer back at base
        target = RD_TOP - DST_BASE;
        @(negedge clk);
        rd_adv = 1'b1;
        repeat (target) @(negedge clk);
        rd_adv = 1'b0;
        chk(rd_ptr == ADDR_W'(RD_TOP), "R10 reach top", rd_ptr, RD_TOP);
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        chk(rd_ptr == ADDR_W'(DST_BASE), "R10 wrap to base", rd_ptr, DST_BASE);
    endtask

    initial begin
        for (int a = 0; a < MEM_SZ; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        run_prep(1, 1, 0, 1'b0);     // unit strides, no offset
        run_prep(7, 13, 3, 1'b0);    // offset 105 wraps once
        run_prep(19, 99, 255, 1'b0); // large offset, stride near window size
        run_prep(99, 2, 1, 1'b0);    // first subset wraps every step
        run_prep(5, 9, 2, 1'b1);     // start during busy is ignored
        t_pointer();
        summary();
        $finish;
    end

endmodule